// File: doc/BRIEF.md
# Configuration Channel Transaction Controller

This block runs single-word configuration transactions against a small table of oscillator frequency words. Software places a value in the outbound data register, then writes the control word. The control word carries a start request, a direction flag, a function code and a device index. The transaction finishes at the same clock edge that stores the control word. A done flag and an error flag in the status register report how it ended. A read transaction copies a table word into the return data register. A write transaction copies the outbound word into the table.

Only function code 1 is legal, and only with a device index below the table size. Any other combination reports an error together with done, and changes nothing else. The table contents are always visible on a flat output bus, so the surrounding clock logic can use them. Each table entry has its own reset value, set by a parameter.

Top module: `cfgchan_ctrl`

## Requirements
- R1: After reset the control register reads 0x00100000. The status, return data and outbound data registers read 0. Table entry i holds bits [32*i+31:32*i] of the ENTRY_RESET parameter.
- R2: Registers sit at byte offsets 0xA0 (return data), 0xA4 (outbound data), 0xA8 (control) and 0xAC (status). A read of any other offset returns 0.
- R3: The control word keeps the device index in bits [11:0], the function code in bits [25:20] and the write flag in bit 30. Bits [19:12], bits [29:26] and the start bit 31 are stored as 0, so start always reads back 0.
- R4: Every write to the control register clears the status register. If bit 31 of the written word is 0, status stays 0 and no transaction happens.
- R5: A control write with start=1 and write flag=1, function 1 and device index below NUM_ENTRIES copies the outbound data into that table entry. Status becomes 1 (done in bit 0).
- R6: A control write with start=1 and write flag=0, function 1 and device index below NUM_ENTRIES loads that table entry into the return data register. Status becomes 1.
- R7: A started transaction with a function code other than 1, or with a device index of NUM_ENTRIES or more, sets status to 3 (done in bit 0 and error in bit 1). The table and the return data register stay unchanged.
- R8: Writes to the status register and to the return data register are ignored.
- R9: The transaction completes at the clock edge that stores the control write. A status read issued in the very next cycle already returns the final status.
- R10: A read request presents its data on bus_rdata with bus_rvalid high in the cycle after the request. bus_rvalid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| osc_table | output | NUM_ENTRIES*32 | Current table words, entry i at bits [32*i+31:32*i] |

## Verification
The hardest case to reach is an illegal transaction that arrives after earlier legal ones have filled both the table and the return data register with known, non-reset values. Only in that state does "left unchanged" mean anything. The stimulus first writes one entry and reads another back, so both targets hold distinctive words. It then fires a write to an out-of-range index and a read with a wrong function code. The table output and the return data register are then checked against the earlier values. The stimulus also writes all-ones to the control word, which both exercises field masking and raises the error path with start set.

// File: rtl/cfgchan_pkg.sv
// Package: shared constants for the configuration channel controller.
// Holds register offsets, control-word field positions and status bit positions.
// Assumes a fixed 32-bit register width.
package cfgchan_pkg;
    localparam int WORD_W     = 32;
    localparam int OFS_W      = 8;

    localparam logic [OFS_W-1:0] OFS_RET  = 8'hA0;
    localparam logic [OFS_W-1:0] OFS_OUT  = 8'hA4;
    localparam logic [OFS_W-1:0] OFS_CTRL = 8'hA8;
    localparam logic [OFS_W-1:0] OFS_STAT = 8'hAC;

    localparam int DEV_LSB  = 0;
    localparam int DEV_W    = 12;
    localparam int FUNC_LSB = 20;
    localparam int FUNC_W   = 6;
    localparam int WR_BIT   = 30;
    localparam int GO_BIT   = 31;

    localparam logic [FUNC_W-1:0] FUNC_OSC = 6'd1;

    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0010_0000;
    localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;

    localparam int ST_DONE = 0;
    localparam int ST_ERR  = 1;

    typedef struct packed {
        logic              go;
        logic              wr;
        logic [FUNC_W-1:0] func;
        logic [DEV_W-1:0]  dev;
    } ctrl_fields_t;

    function automatic ctrl_fields_t split_ctrl(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.go   = w[GO_BIT];
        f.wr   = w[WR_BIT];
        f.func = w[FUNC_LSB +: FUNC_W];
        f.dev  = w[DEV_LSB +: DEV_W];
        return f;
    endfunction
endpackage

// File: rtl/cfgchan_legal.sv
// Module: cfgchan_legal
// Decides whether a function/device pair names a table entry.
// Purely combinational. Assumes NUM_ENTRIES fits in the device index range.
module cfgchan_legal
    import cfgchan_pkg::*;
#(
    parameter int NUM_ENTRIES = 3
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [DEV_W-1:0]  dev,
    output logic              legal
);
    localparam logic [31:0] LIMIT = 32'(NUM_ENTRIES);

    // Legality: the only supported function, and the index is within the table.
    always_comb begin
        legal = (func == FUNC_OSC) && ({20'd0, dev} < LIMIT);
    end
endmodule

// File: rtl/cfgchan_table.sv
// Module: cfgchan_table
// Oscillator word table with one reset value per entry, one write port
// and one combinational read port.
// Assumes wr_idx and rd_idx are only acted on when they are in range.
module cfgchan_table
    import cfgchan_pkg::*;
#(
    parameter int NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*WORD_W-1:0] ENTRY_RESET = '0,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [WORD_W-1:0]             rd_data,
    output logic [NUM_ENTRIES*WORD_W-1:0] flat
);
    logic [WORD_W-1:0] ent [NUM_ENTRIES];

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        // Entry storage: reload the per-entry reset value, or take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= ENTRY_RESET[i*WORD_W +: WORD_W];
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent[i] <= wr_data;
            end
        end
        assign flat[i*WORD_W +: WORD_W] = ent[i];
    end

    // Read mux: pick the addressed entry, or 0 when the index is out of range.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = ent[k];
        end
    end

    // The table changes only when a write is enabled.
    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flat));
endmodule

// File: rtl/cfgchan_regs.sv
// Module: cfgchan_regs
// Register file and transaction sequencer. A control write clears status,
// stores the masked control word and, when start is set, completes the
// transaction at the same edge. Reads return data one cycle after the request.
// Assumes one access per bus_sel cycle; offsets outside the map read as 0.
module cfgchan_regs
    import cfgchan_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_ENTRIES = 3,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              legal,
    output logic [FUNC_W-1:0] chk_func,
    output logic [DEV_W-1:0]  chk_dev,
    output logic              tbl_wr_en,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [WORD_W-1:0] tbl_wr_data,
    input  logic [WORD_W-1:0] tbl_rd_data
);
    logic [WORD_W-1:0] ret_q, out_q, ctrl_q;
    logic [1:0]        stat_q;
    logic              hit_ret, hit_out, hit_ctrl, hit_stat;
    logic              ctrl_wr, fire;
    ctrl_fields_t      cf;

    // Address decode: a match needs every offset bit above the map to be zero.
    always_comb begin
        hit_ret  = (bus_addr == ADDR_W'(OFS_RET));
        hit_out  = (bus_addr == ADDR_W'(OFS_OUT));
        hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
    end

    // Transaction launch: split the incoming control word and qualify start.
    always_comb begin
        ctrl_wr     = bus_sel && bus_wr && hit_ctrl;
        cf          = split_ctrl(bus_wdata);
        fire        = ctrl_wr && cf.go;
        chk_func    = cf.func;
        chk_dev     = cf.dev;
        tbl_idx     = cf.dev[IDX_W-1:0];
        tbl_wr_data = out_q;
        tbl_wr_en   = fire && cf.wr && legal;
    end

    // Outbound data register: plain software write.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else if (bus_sel && bus_wr && hit_out) out_q <= bus_wdata;
    end

    // Control register: store the word with reserved fields and start masked off.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP;
    end

    // Status register: cleared by any control write, then set by a started transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (ctrl_wr) begin
            stat_q[ST_DONE] <= cf.go;
            stat_q[ST_ERR]  <= cf.go && !legal;
        end
    end

    // Return data register: loaded only by a legal started read transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) ret_q <= '0;
        else if (fire && !cf.wr && legal) ret_q <= tbl_rd_data;
    end

    // Read port: register the selected word and strobe it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            if (bus_sel && !bus_wr) begin
                unique case (1'b1)
                    hit_ret:  bus_rdata <= ret_q;
                    hit_out:  bus_rdata <= out_q;
                    hit_ctrl: bus_rdata <= ctrl_q;
                    hit_stat: bus_rdata <= {30'd0, stat_q};
                    default:  bus_rdata <= '0;
                endcase
            end
        end
    end

    assert_done_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_ctrl && bus_wdata[GO_BIT]) |=> stat_q[ST_DONE]);
    assert_err_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[ST_ERR] |-> stat_q[ST_DONE]);
    assert_stat_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_ctrl && !bus_wdata[GO_BIT]) |=> (stat_q == 2'b00));
    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> bus_rvalid);
    assert_ret_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_ret) |=> $stable(ret_q));
    assert_stat_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_stat) |=> $stable(stat_q));
endmodule

// File: rtl/cfgchan_ctrl.sv
// Module: cfgchan_ctrl (top)
// Configuration channel transaction controller: register bus front end,
// legality check and oscillator table.
// Assumes a single clock and a synchronous active-low reset.
module cfgchan_ctrl
    import cfgchan_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int NUM_ENTRIES = 3,
    parameter logic [NUM_ENTRIES*32-1:0] ENTRY_RESET =
        {32'h017D_7840, 32'h0177_0000, 32'h02FA_F080}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_rvalid,
    output logic [NUM_ENTRIES*32-1:0] osc_table
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic              legal;
    logic [FUNC_W-1:0] chk_func;
    logic [DEV_W-1:0]  chk_dev;
    logic              tbl_wr_en;
    logic [IDX_W-1:0]  tbl_idx;
    logic [WORD_W-1:0] tbl_wr_data, tbl_rd_data;

    cfgchan_regs #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .legal(legal), .chk_func(chk_func), .chk_dev(chk_dev),
        .tbl_wr_en(tbl_wr_en), .tbl_idx(tbl_idx),
        .tbl_wr_data(tbl_wr_data), .tbl_rd_data(tbl_rd_data)
    );

    cfgchan_legal #(.NUM_ENTRIES(NUM_ENTRIES)) u_legal (
        .func(chk_func), .dev(chk_dev), .legal(legal)
    );

    cfgchan_table #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_RESET(ENTRY_RESET)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_idx), .wr_data(tbl_wr_data),
        .rd_idx(tbl_idx), .rd_data(tbl_rd_data), .flat(osc_table)
    );
endmodule

// File: tb/cfgchan_ctrl_test.sv
// Scoreboard bench for cfgchan_ctrl: read tasks queue expected words,
// a monitor pops them when bus_rvalid is seen.
module cfgchan_ctrl_test;
    localparam int N = 3;
    localparam logic [31:0] E0 = 32'h02FA_F080;
    localparam logic [31:0] E1 = 32'h0177_0000;
    localparam logic [31:0] E2 = 32'h017D_7840;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N*32-1:0] osc_table;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    cfgchan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .osc_table(osc_table)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic tbl(input int i, input logic [31:0] exp, input string tag);
        @(negedge clk);
        check(tag, osc_table[i*32 +: 32], exp);
    endtask

    // Monitor: compare every read strobe against the queue head.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10 actual=%h expected=no strobe", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: no strobe while idle
        @(negedge clk); check("R10 idle rvalid", {31'd0, bus_rvalid}, 32'd0);
        rd(12'h0A0, 32'h0, "R1 ret reset");
        rd(12'h0A4, 32'h0, "R1 out reset");
        rd(12'h0A8, 32'h0010_0000, "R1 ctrl reset");
        rd(12'h0AC, 32'h0, "R1 stat reset");
        tbl(0, E0, "R1 entry0"); tbl(1, E1, "R1 entry1"); tbl(2, E2, "R1 entry2");
        // R2: map and unmapped offsets
        wr(12'h0A4, 32'hDEAD_BEEF);
        rd(12'h0A4, 32'hDEAD_BEEF, "R2 out readback");
        rd(12'h010, 32'h0, "R2 unmapped 0x10");
        rd(12'h1A8, 32'h0, "R2 alias 0x1A8");
        // R3/R7: all-ones control word, illegal transaction
        wr(12'h0A8, 32'hFFFF_FFFF);
        rd(12'h0AC, 32'h3, "R7 status error");
        rd(12'h0A8, 32'h43F0_0FFF, "R3 masked ctrl");
        tbl(0, E0, "R7 entry0 kept");
        // R5: legal write to entry 1
        wr(12'h0A4, 32'h1234_5678);
        wr(12'h0A8, 32'hC010_0001);
        rd(12'h0AC, 32'h1, "R9 done next cycle");
        tbl(1, 32'h1234_5678, "R5 entry1 written");
        rd(12'h0A8, 32'h4010_0001, "R3 start cleared");
        // R6: legal read of last entry (boundary N-1)
        wr(12'h0A8, 32'h8010_0002);
        rd(12'h0AC, 32'h1, "R6 status done");
        rd(12'h0A0, E2, "R6 ret entry2");
        // R4: control write without start clears status
        wr(12'h0A8, 32'h0010_0001);
        rd(12'h0AC, 32'h0, "R4 status cleared");
        rd(12'h0A0, E2, "R4 ret untouched");
        // R7: out-of-range device write, wrong-function read
        wr(12'h0A4, 32'hAAAA_5555);
        wr(12'h0A8, 32'hC010_0003);
        rd(12'h0AC, 32'h3, "R7 dev=N error");
        tbl(0, E0, "R7 t0"); tbl(1, 32'h1234_5678, "R7 t1"); tbl(2, E2, "R7 t2");
        wr(12'h0A8, 32'h8020_0000);
        rd(12'h0AC, 32'h3, "R7 func=2 error");
        rd(12'h0A0, E2, "R7 ret unchanged");
        // R6: read back the written entry
        wr(12'h0A8, 32'h8010_0001);
        rd(12'h0A0, 32'h1234_5678, "R6 ret entry1");
        // R8: status and return data ignore writes
        wr(12'h0AC, 32'hFFFF_FFFF);
        rd(12'h0AC, 32'h1, "R8 status ignored");
        wr(12'h0A0, 32'h0BAD_F00D);
        rd(12'h0A0, 32'h1234_5678, "R8 ret ignored");
        // R1: reset restores table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        tbl(1, E1, "R1 entry1 after reset");
        rd(12'h0AC, 32'h0, "R1 stat after reset");
        repeat (3) @(negedge clk);
        check("R10 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule